// File: doc/BRIEF.md
# Snooping MSI Line-State Controller

This block is the coherence controller that sits beside one write-back cache in a small bus-based shared-memory multiprocessor. It holds a line state (Modified, Shared or Invalid) and a tag for each entry of a small direct-mapped tag table. It serves processor reads, writes and replacements. It also watches the shared bus for reads and writes from other caches. For each event it works out whether a bus transaction is needed, whether a dirty line must be copied back, and what the line's next state is.

A processor request waits until the bus arbiter grants it. The line update and the bus transaction then complete together in the granted cycle. When a miss lands on an index that holds a dirty line with another tag, the controller first writes that line back and then issues the miss. In any cycle, a foreign snoop to the same index wins over the processor. Copy-backs triggered by snoops come out one cycle later on a dedicated response channel, carrying the line address and the data read from the data array. The data array, the memory and the bus arbiter all lie outside the block.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset, every line is Invalid. No bus request and no copy-back response is active while the processor is idle, and the first access to any address misses.
- R2: A read to a line that is Invalid or holds another clean tag issues a bus read (command 01) for the requested address and leaves the line Shared. A read to a matching line in Shared or Modified completes in the same cycle with no bus request.
- R3: A write to a line that is Invalid, Shared with a matching tag, or clean with another tag issues a bus write (command 10) and leaves the line Modified. A write to a matching Modified line completes in the same cycle with no bus request.
- R4: A foreign snooped read (command 01) that matches a Modified line makes the controller raise the copy-back response in the following cycle, with the snooped address and the data-array word. The line becomes Shared.
- R5: A foreign snooped write (command 10) that matches a Modified line produces the same copy-back response and leaves the line Invalid. One that matches a Shared line leaves it Invalid with no response.
- R6: Replacing a matching Modified line issues a bus copy-back (command 11) with the line's address and data, and leaves the line Invalid. Replacing a matching Shared line invalidates it with no bus request. Replacing a non-matching line completes with no change.
- R7: A snoop that misses the tag, hits an Invalid line, carries command 11, or carries this controller's own ID, causes no response and no state change. A foreign snooped read to a Shared line leaves it Shared.
- R8: While a bus transaction is needed and the grant is low, the request stays asserted with the same command, `cpu_ready` stays low, and no line state changes.
- R9: In a cycle where a foreign snoop targets the same index as a pending processor request, `cpu_ready` and `bus_req` are both low.
- R10: A read or write miss to an index that holds a Modified line with a different tag first issues a bus copy-back of the old line (its own address and data) without completing. The miss then proceeds as from Invalid.
- R11: Processor operations are encoded 00 read, 01 write, 10 replace, and 11 no operation (completes at once). Every bus request carries this controller's ID and a nonzero command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | Processor operation (R11 encoding) |
| cpu_addr | input | ADDR_W | Processor line address: tag in the upper bits, index in the lower IDX_W bits |
| cpu_rdata | input | DATA_W | Data-array word at the processor index |
| cpu_ready | output | 1 | Request completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | Arbiter grant for this cycle |
| bus_cmd | output | 2 | Bus command: 01 read, 10 write, 11 copy-back |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_id | output | ID_W | Requester ID (MY_ID) |
| bus_data | output | DATA_W | Line data on a copy-back, zero otherwise |
| snp_valid | input | 1 | Snooped bus transaction present |
| snp_cmd | input | 2 | Snooped command |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| snp_rdata | input | DATA_W | Data-array word at the snooped index |
| cb_valid | output | 1 | Snoop copy-back response |
| cb_addr | output | ADDR_W | Address of the copied-back line |
| cb_data | output | DATA_W | Data of the copied-back line |

## Verification
The assertions check, on every cycle, the rules that hold at the ports: a snoop copy-back response follows only a foreign read or write snoop and carries its address; a processor request that uses the bus completes only under grant; a same-index snoop blocks the processor side; and bus requests have a legal command, the right ID, and a command type allowed by the operation. The state transitions can only be seen through later behaviour: whether a following read hits, whether a snoop draws a copy-back, and whether a miss writes back a victim first. The bench shows these by sweeping every index through each starting state and each processor and snoop event, then probing the line with a read, all against a state model of its own.

// File: rtl/msi_pkg.sv
// Shared encodings for the snooping MSI controller.
// Assumes a two-bit field for line state, bus command and processor operation.
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_IDLE = 2'd0,
        BC_RD   = 2'd1,
        BC_WR   = 2'd2,
        BC_CB   = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_NOP = 2'd3
    } cpu_op_t;

    typedef struct packed {
        line_st_t nxt;
        logic     upd;
        logic     cb;
    } snoop_act_t;

    // Reaction of a matching valid line to a foreign snooped command.
    function automatic snoop_act_t snoop_react(line_st_t st, bus_cmd_t cmd);
        snoop_act_t a;
        a.nxt = st;
        a.upd = 1'b0;
        a.cb  = 1'b0;
        case (cmd)
            BC_RD: if (st == ST_M) begin
                a.nxt = ST_S;
                a.upd = 1'b1;
                a.cb  = 1'b1;
            end
            BC_WR: if (st != ST_I) begin
                a.nxt = ST_I;
                a.upd = 1'b1;
                a.cb  = (st == ST_M);
            end
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/msi_line_table.sv
// Direct-mapped table of line state and tag, one entry per index.
// Two read ports (processor, snoop) and two write ports; the snoop write wins
// if both target one index (the top module never lets that happen).
module msi_line_table
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cpu_idx,
    output line_st_t         cpu_st,
    output logic [TAG_W-1:0] cpu_tag,
    input  logic [IDX_W-1:0] snp_idx,
    output line_st_t         snp_st,
    output logic [TAG_W-1:0] snp_tag,
    input  logic             cpu_we,
    input  line_st_t         cpu_wst,
    input  logic [TAG_W-1:0] cpu_wtag,
    input  logic             snp_we,
    input  line_st_t         snp_wst
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        // Hold and update one entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[i]  <= ST_I;
                tag_q[i] <= '0;
            end else if (snp_we && snp_idx == IDX_W'(i)) begin
                st_q[i]  <= snp_wst;
            end else if (cpu_we && cpu_idx == IDX_W'(i)) begin
                st_q[i]  <= cpu_wst;
                tag_q[i] <= cpu_wtag;
            end
        end
    end

    // Combinational lookups for both sides.
    always_comb begin
        cpu_st  = st_q[cpu_idx];
        cpu_tag = tag_q[cpu_idx];
        snp_st  = st_q[snp_idx];
        snp_tag = tag_q[snp_idx];
    end

endmodule

// File: rtl/msi_cpu_side.sv
// Processor-side decision logic: hit detection, victim write-back, bus request.
// Assumes the grant is valid in the cycle it is sampled and that the caller
// forces 'blocked' when a snoop owns the same index.
module msi_cpu_side
    import msi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    cpu_valid,
    input  logic [1:0]              cpu_op,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [DATA_W-1:0]       cpu_rdata,
    input  line_st_t                line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  logic                    blocked,
    input  logic                    gnt,
    output logic                    ready,
    output logic                    req,
    output bus_cmd_t                cmd,
    output logic [ADDR_W-1:0]       baddr,
    output logic [DATA_W-1:0]       bdata,
    output logic                    we,
    output line_st_t                wst,
    output logic [ADDR_W-IDX_W-1:0] wtag
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;
    logic             match;
    logic             dirty_victim;
    cpu_op_t          op;

    // Split the address and classify the line.
    always_comb begin
        tag          = cpu_addr[ADDR_W-1:IDX_W];
        idx          = cpu_addr[IDX_W-1:0];
        op           = cpu_op_t'(cpu_op);
        match        = (line_tag == tag) && (line_st != ST_I);
        dirty_victim = (line_st == ST_M) && (line_tag != tag);
    end

    // Decide completion, bus transaction and line update.
    always_comb begin
        ready = 1'b0;
        req   = 1'b0;
        cmd   = BC_IDLE;
        baddr = cpu_addr;
        bdata = '0;
        we    = 1'b0;
        wst   = ST_I;
        wtag  = tag;
        if (cpu_valid && !blocked) begin
            if ((op == OP_RD || op == OP_WR) && dirty_victim) begin
                req   = 1'b1;
                cmd   = BC_CB;
                baddr = {line_tag, idx};
                bdata = cpu_rdata;
                if (gnt) begin
                    we   = 1'b1;
                    wst  = ST_I;
                    wtag = line_tag;
                end
            end else begin
                case (op)
                    OP_RD: begin
                        if (match) begin
                            ready = 1'b1;
                        end else begin
                            req = 1'b1;
                            cmd = BC_RD;
                            if (gnt) begin
                                we    = 1'b1;
                                wst   = ST_S;
                                ready = 1'b1;
                            end
                        end
                    end
                    OP_WR: begin
                        if (match && line_st == ST_M) begin
                            ready = 1'b1;
                        end else begin
                            req = 1'b1;
                            cmd = BC_WR;
                            if (gnt) begin
                                we    = 1'b1;
                                wst   = ST_M;
                                ready = 1'b1;
                            end
                        end
                    end
                    OP_EV: begin
                        if (match && line_st == ST_M) begin
                            req   = 1'b1;
                            cmd   = BC_CB;
                            bdata = cpu_rdata;
                            if (gnt) begin
                                we    = 1'b1;
                                wst   = ST_I;
                                ready = 1'b1;
                            end
                        end else if (match) begin
                            we    = 1'b1;
                            wst   = ST_I;
                            ready = 1'b1;
                        end else begin
                            ready = 1'b1;
                        end
                    end
                    default: ready = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/msi_snoop_side.sv
// Snoop-side logic: matches foreign bus transactions against the table,
// updates the line and registers a copy-back response for the next cycle.
// Assumes the data array presents the word at the snooped index combinationally.
module msi_snoop_side
    import msi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snp_valid,
    input  logic [1:0]              snp_cmd,
    input  logic [ADDR_W-1:0]       snp_addr,
    input  logic [ID_W-1:0]         snp_id,
    input  logic [DATA_W-1:0]       snp_rdata,
    input  line_st_t                line_st,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    output logic                    foreign,
    output logic                    we,
    output line_st_t                wst,
    output logic                    cb_valid,
    output logic [ADDR_W-1:0]       cb_addr,
    output logic [DATA_W-1:0]       cb_data
);
    localparam logic [ID_W-1:0] SELF = ID_W'(MY_ID);

    logic       hit;
    snoop_act_t act;

    // Look up the line and pick its reaction.
    always_comb begin
        foreign = snp_valid && (snp_id != SELF);
        hit     = foreign && (line_tag == snp_addr[ADDR_W-1:IDX_W]) && (line_st != ST_I);
        act     = snoop_react(line_st, bus_cmd_t'(snp_cmd));
        we      = hit && act.upd;
        wst     = act.nxt;
    end

    // Register the copy-back response one cycle after the snoop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cb_valid <= 1'b0;
            cb_addr  <= '0;
            cb_data  <= '0;
        end else begin
            cb_valid <= hit && act.cb;
            if (hit && act.cb) begin
                cb_addr <= snp_addr;
                cb_data <= snp_rdata;
            end
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
// Top of the per-cache MSI coherence controller. Joins the line table, the
// processor side and the snoop side. A foreign snoop to the processor's index
// blocks the processor side for that cycle.
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ID_W-1:0]   bus_id,
    output logic [DATA_W-1:0] bus_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [DATA_W-1:0] snp_rdata,
    output logic              cb_valid,
    output logic [ADDR_W-1:0] cb_addr,
    output logic [DATA_W-1:0] cb_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_t         cpu_st, snp_st, cpu_wst, snp_wst;
    logic [TAG_W-1:0] cpu_tag, snp_tag, cpu_wtag;
    logic             cpu_we, snp_we, foreign, blocked;
    bus_cmd_t         cmd;

    msi_line_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_idx  (cpu_addr[IDX_W-1:0]),
        .cpu_st   (cpu_st),
        .cpu_tag  (cpu_tag),
        .snp_idx  (snp_addr[IDX_W-1:0]),
        .snp_st   (snp_st),
        .snp_tag  (snp_tag),
        .cpu_we   (cpu_we),
        .cpu_wst  (cpu_wst),
        .cpu_wtag (cpu_wtag),
        .snp_we   (snp_we),
        .snp_wst  (snp_wst)
    );

    msi_snoop_side #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
    ) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_cmd   (snp_cmd),
        .snp_addr  (snp_addr),
        .snp_id    (snp_id),
        .snp_rdata (snp_rdata),
        .line_st   (snp_st),
        .line_tag  (snp_tag),
        .foreign   (foreign),
        .we        (snp_we),
        .wst       (snp_wst),
        .cb_valid  (cb_valid),
        .cb_addr   (cb_addr),
        .cb_data   (cb_data)
    );

    // Snoop priority: a foreign snoop on the same index stalls the processor.
    always_comb begin
        blocked = foreign && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);
    end

    msi_cpu_side #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_cpu (
        .cpu_valid (cpu_valid),
        .cpu_op    (cpu_op),
        .cpu_addr  (cpu_addr),
        .cpu_rdata (cpu_rdata),
        .line_st   (cpu_st),
        .line_tag  (cpu_tag),
        .blocked   (blocked),
        .gnt       (bus_gnt),
        .ready     (cpu_ready),
        .req       (bus_req),
        .cmd       (cmd),
        .baddr     (bus_addr),
        .bdata     (bus_data),
        .we        (cpu_we),
        .wst       (cpu_wst),
        .wtag      (cpu_wtag)
    );

    // Drive the bus command and requester ID.
    always_comb begin
        bus_cmd = cmd;
        bus_id  = ID_W'(MY_ID);
    end

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
// Port-level property checker for msi_snoop_ctrl, attached by bind.
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int ID_W   = 2,
    parameter int MY_ID  = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [1:0]        cpu_op,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ID_W-1:0]   bus_id,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic [ID_W-1:0]   snp_id,
    input logic              cb_valid,
    input logic [ADDR_W-1:0] cb_addr
);
    localparam logic [ID_W-1:0] SELF = ID_W'(MY_ID);

    AST_CB_AFTER_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cb_valid |-> ($past(snp_valid) && $past(snp_id) != SELF
                      && ($past(snp_cmd) == 2'd1 || $past(snp_cmd) == 2'd2))); // R4
    AST_CB_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cb_valid |-> cb_addr == $past(snp_addr)); // R5
    AST_DONE_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && bus_req) |-> bus_gnt); // R8
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |-> (!bus_req && !cpu_ready)); // R1
    AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && snp_valid && snp_id != SELF
         && snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]) |-> (!cpu_ready && !bus_req)); // R9
    AST_REQ_ID_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_id == SELF && bus_cmd != 2'd0)); // R11
    AST_EVICT_IS_CB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cpu_op == 2'd2) |-> bus_cmd == 2'd3); // R6
    AST_READ_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cpu_op == 2'd0) |-> bus_cmd != 2'd2); // R2
    AST_WRITE_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && cpu_op == 2'd1) |-> bus_cmd != 2'd1); // R3

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_op    (cpu_op),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_cmd   (bus_cmd),
    .bus_id    (bus_id),
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_addr  (snp_addr),
    .snp_id    (snp_id),
    .cb_valid  (cb_valid),
    .cb_addr   (cb_addr)
);

// File: tb/tb_msi_snoop_ctrl.sv
// Sweep bench: every index, every starting state, every event, then a probe.
module tb_msi_snoop_ctrl;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 2;
    localparam int DATA_W = 16;
    localparam int ID_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_valid = 1'b0;
    logic [1:0]        cpu_op = 2'd0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_rdata = '0;
    logic              cpu_ready;
    logic              bus_req;
    logic              bus_gnt = 1'b0;
    logic [1:0]        bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic [ID_W-1:0]   bus_id;
    logic [DATA_W-1:0] bus_data;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_cmd = 2'd0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic [ID_W-1:0]   snp_id = '0;
    logic [DATA_W-1:0] snp_rdata = '0;
    logic              cb_valid;
    logic [ADDR_W-1:0] cb_addr;
    logic [DATA_W-1:0] cb_data;

    int checks = 0;
    int failures = 0;
    int ms [4];
    int mt [4];

    always #5 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(0)) dut (.*);

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic int rdval(input int a);
        return 16'hC300 + a;
    endfunction

    // Processor request driven to completion with 'stall' grant-low cycles per bus phase.
    task automatic cpu_req(input int op, input int a, input int stall, input string rq);
        int idx = a % 4;
        int tg = a / 4;
        bit done = 0;
        while (!done) begin
            int st = ms[idx];
            bit mt_ok = (mt[idx] == tg) && (st != 0);
            bit bus = 0;
            bit fin = 1;
            int ecmd = 0;
            int eaddr = a;
            int nst = st;
            int ntag = mt[idx];
            string r = rq;
            if ((op == 0 || op == 1) && st == 2 && !mt_ok) begin
                bus = 1; fin = 0; ecmd = 3; eaddr = mt[idx] * 4 + idx; nst = 0; r = "R10";
            end else if (op == 0) begin
                if (!mt_ok) begin bus = 1; ecmd = 1; nst = 1; ntag = tg; end
            end else if (op == 1) begin
                if (!(mt_ok && st == 2)) begin bus = 1; ecmd = 2; nst = 2; ntag = tg; end
            end else if (op == 2) begin
                if (mt_ok && st == 2) begin bus = 1; ecmd = 3; nst = 0; end
                else if (mt_ok) nst = 0;
            end
            if (!bus) begin
                @(negedge clk);
                cpu_valid = 1; cpu_op = op[1:0]; cpu_addr = a[ADDR_W-1:0];
                cpu_rdata = rdval(a); bus_gnt = 0;
                #1;
                chk(cpu_ready == 1'b1 && bus_req == 1'b0, r, "hit ready/req",
                    {cpu_ready, bus_req}, 2);
                @(posedge clk);
            end else begin
                for (int k = 0; k < stall; k++) begin
                    @(negedge clk);
                    cpu_valid = 1; cpu_op = op[1:0]; cpu_addr = a[ADDR_W-1:0];
                    cpu_rdata = rdval(eaddr); bus_gnt = 0;
                    #1;
                    chk(bus_req == 1'b1 && cpu_ready == 1'b0 && bus_cmd == ecmd[1:0], "R8",
                        "stall req/ready/cmd", {bus_req, cpu_ready, bus_cmd}, 8 + ecmd);
                    @(posedge clk);
                end
                @(negedge clk);
                cpu_valid = 1; cpu_op = op[1:0]; cpu_addr = a[ADDR_W-1:0];
                cpu_rdata = rdval(eaddr); bus_gnt = 1;
                #1;
                chk(bus_req == 1'b1 && bus_cmd == ecmd[1:0], r, "bus cmd", {bus_req, bus_cmd}, 4 + ecmd);
                chk(bus_addr == eaddr[ADDR_W-1:0], r, "bus addr", bus_addr, eaddr);
                chk(cpu_ready == fin, r, "grant ready", cpu_ready, fin);
                chk(bus_id == 2'd0, "R11", "bus id", bus_id, 0);
                if (ecmd == 3) chk(bus_data == rdval(eaddr), r, "cb data", bus_data, rdval(eaddr));
                @(posedge clk);
            end
            ms[idx] = nst;
            mt[idx] = ntag;
            done = fin;
        end
        @(negedge clk);
        cpu_valid = 0; bus_gnt = 0;
    endtask

    // Snoop expectation from the model; optionally with a same-index processor request.
    task automatic snoop(input int cmd, input int a, input int id, input bit with_cpu);
        int idx = a % 4;
        int tg = a / 4;
        int st = ms[idx];
        bit hit = (id != 0) && (mt[idx] == tg) && (st != 0);
        bit ecb = hit && st == 2 && (cmd == 1 || cmd == 2);
        int nst = st;
        string r;
        if (hit && cmd == 1 && st == 2) nst = 1;
        if (hit && cmd == 2) nst = 0;
        r = ecb ? ((cmd == 1) ? "R4" : "R5") : ((hit && cmd == 2) ? "R5" : "R7");
        @(negedge clk);
        snp_valid = 1; snp_cmd = cmd[1:0]; snp_addr = a[ADDR_W-1:0];
        snp_id = id[ID_W-1:0]; snp_rdata = 16'h5A00 + a[15:0];
        if (with_cpu) begin
            cpu_valid = 1; cpu_op = 2'd1; cpu_addr = a[ADDR_W-1:0] ^ 6'h24; bus_gnt = 1;
            #1;
            if (id != 0)
                chk(cpu_ready == 1'b0 && bus_req == 1'b0, "R9", "blocked ready/req",
                    {cpu_ready, bus_req}, 0);
        end
        @(posedge clk);
        @(negedge clk);
        snp_valid = 0; cpu_valid = 0; bus_gnt = 0;
        #1;
        chk(cb_valid == ecb, r, "cb valid", cb_valid, ecb);
        if (ecb) begin
            chk(cb_addr == a[ADDR_W-1:0], r, "cb addr", cb_addr, a);
            chk(cb_data == 16'h5A00 + a[15:0], r, "cb data", cb_data, 16'h5A00 + a);
        end
        ms[idx] = nst;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin ms[i] = 0; mt[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(bus_req == 1'b0 && cb_valid == 1'b0 && cpu_ready == 1'b0, "R1", "reset outputs",
            {bus_req, cb_valid, cpu_ready}, 0);
        // R1: first read of address 0 (tag 0 after reset) must miss.
        cpu_req(0, 0, 1, "R1");
        cpu_req(3, 5, 0, "R11");
        for (int idx = 0; idx < 4; idx++) begin
            for (int setup = 0; setup < 3; setup++) begin
                for (int ev = 0; ev < 10; ev++) begin
                    int a = idx + 4 * ((setup * 5 + ev + idx) % 16);
                    int other = a ^ 6'h20;
                    int stall = (ev + setup) % 3;
                    cpu_req(2, a, stall, "R6");
                    if (setup >= 1) cpu_req(0, a, stall, "R2");
                    if (setup == 2) cpu_req(1, a, stall, "R3");
                    case (ev)
                        0: cpu_req(0, a, stall, "R2");
                        1: cpu_req(1, a, stall, "R3");
                        2: cpu_req(2, a, stall, "R6");
                        3: cpu_req(0, other, stall, "R2");
                        4: snoop(1, a, 1, 0);
                        5: snoop(2, a, 2, 0);
                        6: snoop(3, a, 1, 0);
                        7: snoop(2, a, 0, 0);
                        8: snoop(2, other, 3, 0);
                        default: snoop(1 + setup % 2, a, 1, 1);
                    endcase
                    cpu_req(0, a, stall, "R2");
                    cpu_req(1, other, stall, "R3");
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule